// File: doc/BRIEF.md
# Rename-Stage Slot Accounting Unit

This block watches an eight-wide rename stage and sorts every slot it sees into one of six buckets. Four buckets count waste. A slot is lost to frontend latency when nothing arrived. It is lost to frontend bandwidth when only part of the width arrived. It is lost to core stall or memory stall when the backend refused work; the kind of instruction blocking retirement decides which of the two. The other two buckets count filled slots. A filled slot ends as retiring useful work or as wrong-path (bad speculation) work.

A filled slot cannot be judged when it is filled. It waits in a pending tally until the retirement logic or the flush logic reports its fate. These reports arrive as per-slot bit vectors. Each buckets' total sits in a saturating counter, and a combinational select port reads one counter at a time. A synchronous clear zeroes all state, and an enable pauses all accounting.

Top module: `slot_class_top`

## Requirements
- R1: After reset, every readable value (all six counters and the pending tally) reads zero.
- R2: With `be_ready`=1 and `fe_cnt`=0, the frontend-latency counter (select 2) grows by 8 and nothing else changes, apart from resolutions.
- R3: With `be_ready`=1 and 1..8 delivered, the pending tally (select 6) grows by the delivered count and the frontend-bandwidth counter (select 3) grows by 8 minus that count. `fe_cnt` values above 8 count as 8.
- R4: With `be_ready`=0 and `blk_load`=0, the core-stall counter (select 4) grows by 8, and `fe_cnt` has no effect.
- R5: With `be_ready`=0 and `blk_load`=1, the memory-stall counter (select 5) grows by 8.
- R6: The number of set bits in `ret_vec` moves from the pending tally into the retiring counter (select 0) in the same cycle. The caller never reports more outcomes than are pending.
- R7: The number of set bits in `flush_vec` moves from the pending tally into the bad-speculation counter (select 1).
- R8: A counter that would pass its maximum holds at all ones and never wraps.
- R9: `clr`=1 zeroes all counters and the pending tally on the next edge, whatever `en` is.
- R10: With `en`=0, all counters and the pending tally hold, and `ret_vec`/`flush_vec` are ignored.
- R11: In every enabled cycle, the slots added to the four loss buckets plus the slots added to pending total exactly 8.
- R12: `rd_data` shows, without delay, the value picked by `rd_sel` (0 retiring, 1 bad speculation, 2 frontend latency, 3 frontend bandwidth, 4 core stall, 5 memory stall, 6 pending). Code 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all state |
| en | input | 1 | Accounting enable |
| fe_cnt | input | 4 | Micro-ops offered by the frontend this cycle |
| be_ready | input | 1 | Backend can accept micro-ops |
| blk_load | input | 1 | Oldest unretired op is a load |
| ret_vec | input | 8 | One bit per pending op that retired |
| flush_vec | input | 8 | One bit per pending op that was flushed |
| rd_sel | input | 3 | Readout select |
| rd_data | output | CW | Selected value |

## Verification
Slot classification and outcome resolution both act on the pending tally. They often fall in the same cycle: new fills add to it while retire and flush vectors drain it. The random phase provokes this overlap almost every cycle, with backend stalls mixed in. After each edge the bench compares all seven readouts with a bench model. A separate enabled window checks that the grand total of all buckets plus pending grows by exactly eight per cycle, since resolutions only move slots between buckets.

// File: rtl/slot_class_pkg.sv
package slot_class_pkg;
    localparam int SLOT_N = 8;
    localparam int ADD_W  = $clog2(SLOT_N + 1);
    localparam int NCAT   = 6;

    typedef enum logic [2:0] {
        CAT_RET  = 3'd0,
        CAT_BAD  = 3'd1,
        CAT_FLAT = 3'd2,
        CAT_FBW  = 3'd3,
        CAT_CORE = 3'd4,
        CAT_MEM  = 3'd5,
        SEL_PEND = 3'd6,
        SEL_NONE = 3'd7
    } sel_e;

    typedef struct packed {
        logic [ADD_W-1:0] fill;
        logic [ADD_W-1:0] fe_lat;
        logic [ADD_W-1:0] fe_bw;
        logic [ADD_W-1:0] core;
        logic [ADD_W-1:0] mem;
    } split_t;
endpackage

// File: rtl/slot_split.sv
module slot_split
    import slot_class_pkg::*;
(
    input  logic [ADD_W-1:0] fe_cnt,
    input  logic             be_ready,
    input  logic             blk_load,
    output split_t           split
);
    logic [ADD_W-1:0] clamped;

    always_comb begin
        clamped = (fe_cnt > ADD_W'(SLOT_N)) ? ADD_W'(SLOT_N) : fe_cnt;
        split   = '0;
        if (!be_ready) begin
            if (blk_load) split.mem  = ADD_W'(SLOT_N);
            else          split.core = ADD_W'(SLOT_N);
        end else if (clamped == '0) begin
            split.fe_lat = ADD_W'(SLOT_N);
        end else begin
            split.fill  = clamped;
            split.fe_bw = ADD_W'(SLOT_N) - clamped;
        end
    end
endmodule

// File: rtl/sat_ctr.sv
module sat_ctr
    import slot_class_pkg::*;
#(
    parameter int CW = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [ADD_W-1:0] add,
    output logic [CW-1:0]    cnt
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW:0]   sum;

    always_comb begin
        sum   = {1'b0, cnt_q} + (CW+1)'(add);
        cnt_d = cnt_q;
        if (clr)     cnt_d = '0;
        else if (en) cnt_d = sum[CW] ? '1 : sum[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt_q >= $past(cnt_q));
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);
    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/slot_class_top.sv
module slot_class_top
    import slot_class_pkg::*;
#(
    parameter int CW     = 48,
    parameter int PEND_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic [ADD_W-1:0]    fe_cnt,
    input  logic                be_ready,
    input  logic                blk_load,
    input  logic [SLOT_N-1:0]   ret_vec,
    input  logic [SLOT_N-1:0]   flush_vec,
    input  logic [2:0]          rd_sel,
    output logic [CW-1:0]       rd_data
);
    typedef struct packed {
        logic [PEND_W-1:0] pend;
    } state_t;

    state_t           st_d, st_q;
    split_t           split;
    logic [ADD_W-1:0] n_ret, n_bad;
    logic [ADD_W-1:0] add_a [NCAT];
    logic [CW-1:0]    cnt_a [NCAT];

    slot_split u_split (
        .fe_cnt   (fe_cnt),
        .be_ready (be_ready),
        .blk_load (blk_load),
        .split    (split)
    );

    always_comb begin
        n_ret = ADD_W'($countones(ret_vec));
        n_bad = ADD_W'($countones(flush_vec));
        add_a[CAT_RET]  = n_ret;
        add_a[CAT_BAD]  = n_bad;
        add_a[CAT_FLAT] = split.fe_lat;
        add_a[CAT_FBW]  = split.fe_bw;
        add_a[CAT_CORE] = split.core;
        add_a[CAT_MEM]  = split.mem;
        st_d = st_q;
        if (clr)
            st_d.pend = '0;
        else if (en)
            st_d.pend = st_q.pend + PEND_W'(split.fill)
                      - PEND_W'(n_ret) - PEND_W'(n_bad);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NCAT; g++) begin : g_ctr
        sat_ctr #(.CW(CW)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .en    (en),
            .add   (add_a[g]),
            .cnt   (cnt_a[g])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_PEND)     rd_data = CW'(st_q.pend);
        else if (rd_sel != SEL_NONE) rd_data = cnt_a[rd_sel];
    end

    assert_slot_total_R11: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (int'(split.fill) + int'(split.fe_lat) + int'(split.fe_bw)
                + int'(split.core) + int'(split.mem)) == SLOT_N);
    assert_stall_no_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !be_ready |-> split.fill == '0);
    assert_pend_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.pend == '0);
    assert_pend_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(st_q.pend));
endmodule

// File: tb/slot_class_top_tb_top.sv
module slot_class_top_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CW   = 12;
    localparam int PW   = 10;
    localparam longint MAXV = (64'd1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0, en = 1'b0, be_ready = 1'b1, blk_load = 1'b0;
    logic [3:0]    fe_cnt = '0;
    logic [7:0]    ret_vec = '0, flush_vec = '0;
    logic [2:0]    rd_sel = '0;
    logic [CW-1:0] rd_data;

    int checks = 0, failures = 0;
    longint expv [8];

    always #2 clk = ~clk;

    slot_class_top #(.CW(CW), .PEND_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .fe_cnt(fe_cnt),
        .be_ready(be_ready), .blk_load(blk_load), .ret_vec(ret_vec),
        .flush_vec(flush_vec), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic string tag_of(int s);
        case (s)
            0: return "R6"; 1: return "R7"; 2: return "R2"; 3: return "R3";
            4: return "R4"; 5: return "R5"; 6: return "R3"; default: return "R12";
        endcase
    endfunction

    function automatic longint sat_add(longint a, longint b);
        return (a + b > MAXV) ? MAXV : a + b;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic read(int s, output longint v);
        rd_sel = 3'(s);
        #0.1;
        v = longint'(rd_data);
    endtask

    task automatic check_all(string over);
        longint v;
        for (int s = 0; s < 8; s++) begin
            read(s, v);
            chk(v == expv[s], (over != "") ? over : tag_of(s), v, expv[s]);
        end
    endtask

    task automatic model_step();
        int n;
        if (clr) begin
            for (int s = 0; s < 8; s++) expv[s] = 0;
            return;
        end
        if (!en) return;
        expv[0] = sat_add(expv[0], $countones(ret_vec));
        expv[1] = sat_add(expv[1], $countones(flush_vec));
        expv[6] = expv[6] - $countones(ret_vec) - $countones(flush_vec);
        n = (fe_cnt > 8) ? 8 : int'(fe_cnt);
        if (!be_ready) begin
            if (blk_load) expv[5] = sat_add(expv[5], 8);
            else          expv[4] = sat_add(expv[4], 8);
        end else if (n == 0) begin
            expv[2] = sat_add(expv[2], 8);
        end else begin
            expv[6] = expv[6] + n;
            expv[3] = sat_add(expv[3], 8 - n);
        end
    endtask

    task automatic cycle(bit do_check);
        @(posedge clk);
        model_step();
        @(negedge clk);
        if (do_check) check_all("");
    endtask

    task automatic random_inputs(bit allow_off);
        int r, f, p;
        p = int'(expv[6]);
        fe_cnt   = 4'($urandom_range(0, 9));
        be_ready = ($urandom_range(0, 3) != 0);
        blk_load = $urandom_range(0, 1);
        en       = allow_off ? ($urandom_range(0, 9) != 0) : 1'b1;
        r = $urandom_range(3, 8); if (r > p) r = p;
        f = $urandom_range(0, 2); if (f > p - r) f = p - r;
        ret_vec   = 8'((16'd1 << r) - 1);
        flush_vec = 8'(((16'd1 << f) - 1) << (8 - f));
        clr = 1'b0;
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        longint tot0, tot1, v, hold [8];
        void'($urandom(32'h5107_C1A5));
        for (int s = 0; s < 8; s++) expv[s] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // mixed random phase: fills and resolutions overlap
        for (int i = 0; i < 300; i++) begin
            random_inputs(1'b1);
            cycle(1'b1);
        end

        // R11: grand total grows by 8 per enabled cycle
        tot0 = 0;
        for (int s = 0; s < 7; s++) begin read(s, v); tot0 += v; end
        for (int i = 0; i < 40; i++) begin
            random_inputs(1'b0);
            cycle(1'b0);
        end
        tot1 = 0;
        for (int s = 0; s < 7; s++) begin read(s, v); tot1 += v; end
        chk(tot1 - tot0 == 320, "R11", tot1 - tot0, 320);

        // R10: disabled cycle with activity changes nothing
        for (int s = 0; s < 8; s++) read(s, hold[s]);
        en = 1'b0; be_ready = 1'b1; fe_cnt = 4'd3;
        ret_vec = (expv[6] > 0) ? 8'h01 : 8'h00; flush_vec = 8'h00;
        cycle(1'b0);
        for (int s = 0; s < 8; s++) begin
            read(s, v);
            chk(v == hold[s], "R10", v, hold[s]);
        end

        // R9: clear wins even with enable low
        clr = 1'b1; en = 1'b0;
        cycle(1'b0);
        check_all("R9");
        clr = 1'b0;

        // directed: full delivery, stall core, stall memory, clamp
        en = 1'b1; ret_vec = '0; flush_vec = '0;
        be_ready = 1'b1; fe_cnt = 4'd8; cycle(1'b0); check_all("R3");
        be_ready = 1'b0; blk_load = 1'b0; fe_cnt = 4'd5; cycle(1'b0); check_all("R4");
        blk_load = 1'b1; cycle(1'b0); check_all("R5");
        be_ready = 1'b1; fe_cnt = 4'd15; cycle(1'b0); check_all("R3");

        // R8: saturate frontend-latency counter
        fe_cnt = 4'd0;
        for (int i = 0; i < 520; i++) cycle(1'b0);
        read(2, v);
        chk(v == MAXV, "R8", v, MAXV);
        cycle(1'b0);
        read(2, v);
        chk(v == MAXV, "R8", v, MAXV);
        check_all("");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule